// File: doc/BRIEF.md
# Peripheral Interrupt Event Aggregator

This block gathers the single-cycle event pulses of one peripheral and turns them into a single level-sensitive interrupt request for a top-level interrupt controller. Every event has a sticky pending bit. The pending bit latches whenever its event fires, whatever the enable state. A per-event enable mask decides which pending bits may drive the request line. Software reads the pending bits over a small register bus and clears them by writing ones.

The block keeps no count and no queue. When an enabled event fires again while its pending bit is still set and not being cleared, the repeat is lost. The loss is recorded in a separate sticky lost-event register, and a summary output reports it. The request output is registered, so it follows the pending and enable state one clock later.

Registers sit at word offsets on a byte address: pending at 0x0, enable at 0x4, lost-event at 0x8. All other offsets read as zero.

Top module: `evt_mgr`

## Requirements
- R1: A pulse on `evt_i[n]` sets pending bit n at the next clock edge, whatever the value of enable bit n.
- R2: A bus write to offset 0x0 clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: When `evt_i[n]` pulses in the same cycle as a write-1 clear of pending bit n, the bit stays set.
- R4: The enable register at offset 0x4 is read/write. A 1 in bit n enables event n and a 0 disables it.
- R5: `irq_o` is low while no bit is both pending and enabled.
- R6: Setting the enable bit of an event that is already pending raises `irq_o`.
- R7: An event pulse on bit n records lost-event bit n when all of these hold: pending bit n is set, enable bit n is set, and the bit is not being cleared in the same cycle. Repeats of a disabled event record nothing.
- R8: `irq_o` stays high as long as any bit is both pending and enabled. It falls only once every such bit has been cleared.
- R9: After reset, the pending, enable and lost-event registers read 0, and `irq_o` and `miss_o` are low.
- R10: An event that coincides with the clearing of its own pending bit does not record a lost event.
- R11: Reads at any offset other than 0x0, 0x4 and 0x8 return 0. Writes to such offsets change no register.
- R12: `irq_o` is registered and changes one clock edge after the pending and enable state that causes the change.
- R13: The lost-event register at offset 0x8 is cleared by writing 1 to a bit. A new loss in the same cycle as that bit's clear keeps the bit set. `miss_o` is the OR of all lost-event bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Single-cycle event pulses, one per source |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NUM_EVT | Write data |
| bus_rdata | output | NUM_EVT | Read data; zero when not reading |
| irq_o | output | 1 | Registered level interrupt request |
| miss_o | output | 1 | High while any lost-event bit is set |

## Verification
A wrong pending bit is visible on a read of offset 0x0 in the cycle right after the event. It also reaches `irq_o` one cycle later, but only when that bit is enabled. A corrupted enable bit stays hidden at the interrupt pin until its pending bit is set, so the bench reads the enable register back directly. A miss-detection error, such as counting a coincident clear as a loss, changes `miss_o` and the 0x8 readback on the next edge. For this reason the bench reads the lost-event register after every scenario that could touch it.

// File: rtl/evt_mgr_pkg.sv
package evt_mgr_pkg;
  localparam int unsigned OFS_PEND = 0;
  localparam int unsigned OFS_ENAB = 4;
  localparam int unsigned OFS_LOST = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENAB = 2'd2,
    SEL_LOST = 2'd3
  } evt_sel_e;
endpackage

// File: rtl/evt_bus_port.sv
module evt_bus_port
  import evt_mgr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_EVT-1:0] bus_wdata,
  input  logic [NUM_EVT-1:0] pend_i,
  input  logic [NUM_EVT-1:0] lost_i,
  output logic [NUM_EVT-1:0] enab_o,
  output logic [NUM_EVT-1:0] clr_pend_o,
  output logic [NUM_EVT-1:0] clr_lost_o,
  output logic [NUM_EVT-1:0] bus_rdata
);
  evt_sel_e           sel;
  logic [NUM_EVT-1:0] enab_q;
  logic [NUM_EVT-1:0] enab_d;
  logic               enab_en;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_PEND))      sel = SEL_PEND;
    else if (bus_addr == ADDR_W'(OFS_ENAB)) sel = SEL_ENAB;
    else if (bus_addr == ADDR_W'(OFS_LOST)) sel = SEL_LOST;
  end

  // write side
  always_comb begin
    enab_en    = bus_wr && (sel == SEL_ENAB);
    enab_d     = bus_wdata;
    clr_pend_o = (bus_wr && (sel == SEL_PEND)) ? bus_wdata : '0;
    clr_lost_o = (bus_wr && (sel == SEL_LOST)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enab_q <= '0;
    else if (enab_en) enab_q <= enab_d;
  end

  assign enab_o = enab_q;

  // read side
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_PEND: bus_rdata = pend_i;
        SEL_ENAB: bus_rdata = enab_q;
        SEL_LOST: bus_rdata = lost_i;
        default:  bus_rdata = '0;
      endcase
    end
  end

  a_r4_enab_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ENAB)) |=> (enab_q == $past(bus_wdata)));

  a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != ADDR_W'(OFS_PEND) && bus_addr != ADDR_W'(OFS_ENAB)
     && bus_addr != ADDR_W'(OFS_LOST)) |-> (bus_rdata == '0));

  a_r11_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFS_ENAB)) |=> $stable(enab_q));
endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] pend_o
);
  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] pend_d;
  logic [NUM_EVT-1:0] pend_en;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
    // a new event outranks a clear in the same cycle
    assign pend_d[g]  = evt_i[g] | (pend_q[g] & ~clr_i[g]);
    assign pend_en[g] = evt_i[g] | clr_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[g] <= 1'b0;
      else if (pend_en[g]) pend_q[g] <= pend_d[g];
    end
  end

  assign pend_o = pend_q;

  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  a_r2_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));

  a_r1_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/evt_lost_bank.sv
module evt_lost_bank #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] pend_i,
  input  logic [NUM_EVT-1:0] enab_i,
  input  logic [NUM_EVT-1:0] clr_pend_i,
  input  logic [NUM_EVT-1:0] clr_lost_i,
  output logic [NUM_EVT-1:0] lost_o,
  output logic               any_lost_o
);
  logic [NUM_EVT-1:0] lost_q;
  logic [NUM_EVT-1:0] lost_d;
  logic [NUM_EVT-1:0] hit;
  logic               lost_en;

  always_comb begin
    // a repeat is lost only if the earlier event is still unacknowledged
    hit     = evt_i & pend_i & enab_i & ~clr_pend_i;
    lost_d  = hit | (lost_q & ~clr_lost_i);
    lost_en = |(hit | clr_lost_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lost_q <= '0;
    else if (lost_en) lost_q <= lost_d;
  end

  assign lost_o     = lost_q;
  assign any_lost_o = |lost_q;

  a_r10_rise_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lost_q & ~$past(lost_q) & ~($past(pend_i) & $past(enab_i) & ~$past(clr_pend_i))) == '0));

  a_r13_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lost_q) & ~lost_q & ~$past(clr_lost_i)) == '0));

  a_r7_disabled_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lost_q & ~$past(lost_q) & ~$past(enab_i)) == '0));
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] pend_i,
  input  logic [NUM_EVT-1:0] enab_i,
  output logic               irq_o
);
  logic irq_q;
  logic irq_d;
  logic irq_en;

  always_comb begin
    irq_d  = |(pend_i & enab_i);
    irq_en = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  a_r6_enabled_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_i & enab_i)) |=> irq_q);

  a_r5_no_source_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_i & enab_i)) |=> !irq_q);
endmodule

// File: rtl/evt_mgr.sv
module evt_mgr #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_EVT-1:0] bus_wdata,
  output logic [NUM_EVT-1:0] bus_rdata,
  output logic               irq_o,
  output logic               miss_o
);
  logic [NUM_EVT-1:0] pend;
  logic [NUM_EVT-1:0] enab;
  logic [NUM_EVT-1:0] lost;
  logic [NUM_EVT-1:0] clr_pend;
  logic [NUM_EVT-1:0] clr_lost;

  evt_bus_port #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_i(pend), .lost_i(lost),
    .enab_o(enab), .clr_pend_o(clr_pend), .clr_lost_o(clr_lost),
    .bus_rdata(bus_rdata)
  );

  evt_pend_bank #(.NUM_EVT(NUM_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_pend), .pend_o(pend)
  );

  evt_lost_bank #(.NUM_EVT(NUM_EVT)) u_lost (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .pend_i(pend), .enab_i(enab),
    .clr_pend_i(clr_pend), .clr_lost_i(clr_lost), .lost_o(lost),
    .any_lost_o(miss_o)
  );

  evt_irq_out #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .irq_o(irq_o)
  );

  a_r8_irq_implies_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(pend & enab)));
endmodule

// File: tb/evt_mgr_bench.sv
module evt_mgr_bench;
  localparam int N = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          irq_o;
  logic          miss_o;

  always #4 clk = ~clk; // 125 MHz

  evt_mgr #(.NUM_EVT(N), .ADDR_W(AW)) u_evt_mgr (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .miss_o(miss_o)
  );

  // sel: 0 = read data, 1 = irq_o, 2 = miss_o
  typedef struct {
    int         sel;
    logic [N-1:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // monitor: compares everything queued for the current cycle, away from the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = bus_rdata;
        1:       act = {{(N-1){1'b0}}, irq_o};
        default: act = {{(N-1){1'b0}}, miss_o};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic exp_pin(int sel, logic [N-1:0] exp, string tag);
    q.push_back('{sel, exp, tag});
  endtask

  task automatic rd_check(logic [AW-1:0] a, logic [N-1:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    q.push_back('{0, exp, tag});
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(logic [N-1:0] e);
    evt_i = e;
    tick();
    evt_i = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R9 reset state
    exp_pin(1, 0, "R9 irq after reset");
    exp_pin(2, 0, "R9 miss after reset");
    rd_check(4'h0, 8'h00, "R9 pending reset");
    rd_check(4'h4, 8'h00, "R9 enable reset");
    rd_check(4'h8, 8'h00, "R9 lost reset");

    // R1 events latch with mask clear
    pulse(8'h05);
    rd_check(4'h0, 8'h05, "R1 pending set while disabled");
    exp_pin(1, 0, "R5 irq low with nothing enabled");
    tick();

    // R6/R12 enabling an already pending bit
    wr(4'h4, 8'h04);
    exp_pin(1, 0, "R12 irq one edge after enable");
    tick();
    exp_pin(1, 1, "R6 irq up after enabling pending bit");

    // R2 write-0 ignored, write-1 clears
    wr(4'h0, 8'h00);
    rd_check(4'h0, 8'h05, "R2 write of zero keeps pending");
    wr(4'h0, 8'h04);
    tick();
    exp_pin(1, 0, "R8 irq low once enabled bit cleared");
    rd_check(4'h0, 8'h01, "R2 write of one clears bit");

    // R4 enable readback
    wr(4'h4, 8'h03);
    rd_check(4'h4, 8'h03, "R4 enable readback");
    exp_pin(1, 1, "R6 irq from pending bit0");

    // R7 repeat of enabled pending event
    pulse(8'h03);
    exp_pin(2, 1, "R7 miss_o after repeat");
    rd_check(4'h8, 8'h01, "R7 lost bit0 only");
    rd_check(4'h0, 8'h03, "R1 bit1 pending");

    // R7 repeats of a disabled event are not losses
    pulse(8'h04);
    pulse(8'h04);
    rd_check(4'h8, 8'h01, "R7 disabled repeat not lost");
    rd_check(4'h0, 8'h07, "R1 disabled event pending");

    // R3/R10 event coincides with clear of its bit
    evt_i = 8'h02;
    wr(4'h0, 8'h02);
    evt_i = '0;
    rd_check(4'h0, 8'h07, "R3 event wins over clear");
    rd_check(4'h8, 8'h01, "R10 no loss on coincident clear");

    // R8 irq held while any enabled bit pending
    wr(4'h0, 8'h01);
    tick();
    exp_pin(1, 1, "R8 irq held by bit1");
    wr(4'h0, 8'h02);
    tick();
    exp_pin(1, 0, "R8 irq drops after last enabled clear");
    rd_check(4'h0, 8'h04, "R2 only bit2 left");

    // R13 lost clear vs simultaneous new loss
    wr(4'h4, 8'h07);
    pulse(8'h04);
    rd_check(4'h8, 8'h05, "R7 lost bit2 recorded");
    evt_i = 8'h04;
    wr(4'h8, 8'h05);
    evt_i = '0;
    rd_check(4'h8, 8'h04, "R13 new loss wins over clear");
    wr(4'h8, 8'h04);
    exp_pin(2, 0, "R13 miss_o low after clear");
    rd_check(4'h8, 8'h00, "R13 lost cleared");

    // R11 unmapped offsets
    wr(4'hC, 8'hFF);
    rd_check(4'hC, 8'h00, "R11 unmapped read zero");
    rd_check(4'h4, 8'h07, "R11 enable untouched by unmapped write");
    rd_check(4'h0, 8'h04, "R11 pending untouched by unmapped write");

    tick();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule